// File: doc/BRIEF.md
# Packed Alternating Multiply-Add Lane Controller

This block sequences one packed single-precision fused operation. Even lanes compute product plus addend and odd lanes compute product minus addend, across 4, 8 or 16 lanes of 32 bits each. It does no floating-point arithmetic itself. It takes three source vectors and routes them into per-lane (multiplicand, multiplier, addend) triples according to an operand ordering code. It applies an optional scalar broadcast of the third source and tags odd lanes for subtraction. It then sends the triples to external arithmetic lane units in a single request pulse.

When every lane unit reports completion, the block collects the lanes' rounded results. It applies per-lane write masking in merge or zero mode and clears every bit above the active vector length. It presents the finished 512-bit destination with a one-cycle result pulse. The rounding mode sent to the lanes is the global one, except in a single operand-override case. The exception flags of the lanes that write are ORed into one flag word.

A new operation is taken only while `op_ready` is high. The request pulse follows one cycle after acceptance. The result pulse follows one cycle after the cycle in which all done bits are sampled high, and that sampling begins only after the request cycle.

Top module: `fmsa_lane_ctrl`

## Requirements
- R1: `len_sel` sets the active lane count: 0 gives 4 lanes, 1 gives 8 lanes, 2 or 3 gives 16 lanes. `lane_act[j]` is 1 exactly for j below that count.
- R2: `lane_sub[j]` is 0 for even j (add) and 1 for odd j (subtract).
- R3: With ordering code 0 or 3, lane j gets a = dest element, b = third-source element, c = second-source element.
- R4: With ordering code 1, lane j gets a = second-source element, b = dest element, c = third-source element.
- R5: With ordering code 2, lane j gets a = second-source element, b = third-source element, c = dest element.
- R6: When `src3_mem` and `ctl_bit` are both 1, bits [31:0] of `src3_in` are used as the third-source element in every lane. When `src3_mem` is 0, `ctl_bit` does not broadcast.
- R7: `lane_rc` equals `rc_op` only when `len_sel` is 2 or 3, `src3_mem` is 0 and `ctl_bit` is 1. In every other case it equals `rc_glb`.
- R8: With `mask_on` 0, every active lane of `res_data` holds that lane's `lane_res` element.
- R9: With `mask_on` 1 and `zero_mode` 0, an active lane whose `mask_bits` bit is 0 keeps its `dest_in` element.
- R10: With `mask_on` 1 and `zero_mode` 1, an active lane whose `mask_bits` bit is 0 is written with zero.
- R11: Every lane at or above the active lane count is zero in `res_data`, whatever its `lane_res` holds.
- R12: `res_flags` is the OR of the 5-bit `lane_flags` fields of the active lanes that write. Masked-off and inactive lanes add nothing.
- R13: `lane_req_valid` is a one-cycle pulse in the cycle after acceptance (`op_valid` and `op_ready`). `op_valid` is ignored while `op_ready` is low. `res_valid` is a one-cycle pulse in the cycle after all `lane_done` bits are high, which counts only after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle, operation can be taken |
| ord_sel | input | 2 | Operand ordering code (0/3: 132, 1: 213, 2: 231) |
| len_sel | input | 2 | Vector length code (0: 128, 1: 256, 2/3: 512 bits) |
| src3_mem | input | 1 | Third source is a memory operand |
| ctl_bit | input | 1 | Broadcast (memory) or rounding override (register) |
| mask_on | input | 1 | Write masking enabled |
| zero_mode | input | 1 | Masked-off lanes are zeroed rather than kept |
| mask_bits | input | 16 | Per-lane write mask |
| rc_op | input | 2 | Rounding mode carried by the operation |
| rc_glb | input | 2 | Rounding mode from the global control register |
| dest_in | input | 512 | Destination / first source vector |
| src2_in | input | 512 | Second source vector |
| src3_in | input | 512 | Third source vector |
| lane_req_valid | output | 1 | Request pulse to lane units |
| lane_a | output | 512 | Per-lane multiplicand |
| lane_b | output | 512 | Per-lane multiplier |
| lane_c | output | 512 | Per-lane addend |
| lane_sub | output | 16 | Per-lane subtract select |
| lane_act | output | 16 | Lane lies inside the active length |
| lane_rc | output | 2 | Rounding mode for all lanes |
| lane_done | input | 16 | Per-lane completion |
| lane_res | input | 512 | Per-lane rounded results |
| lane_flags | input | 80 | Per-lane 5-bit exception flags |
| res_valid | output | 1 | Result pulse |
| res_data | output | 512 | Merged destination |
| res_flags | output | 5 | ORed exception flags |

## Verification
The bench builds the block with its default of 16 lanes, so the full 512-bit register is present. All three vector lengths are therefore in reach, including the clearing of lanes 4 to 15 and 8 to 15 while the lane model returns non-zero data there. With all 16 lanes present, the two length codes that both mean 512 bits can be told apart from the shorter lengths. So can the rounding-override case, which exists only at full length. Flag planting in chosen lanes lets a masked-off lane's flags be told apart from those of the lanes that write.

// File: rtl/fmsa_pkg.sv
package fmsa_pkg;

  localparam int ELEM_W = 32;
  localparam int RC_W   = 2;

  typedef enum logic [1:0] {
    ORD_132 = 2'd0,
    ORD_213 = 2'd1,
    ORD_231 = 2'd2,
    ORD_ALT = 2'd3
  } ord_e;

  typedef enum logic [1:0] {
    LEN_128 = 2'd0,
    LEN_256 = 2'd1,
    LEN_512 = 2'd2,
    LEN_ALT = 2'd3
  } len_e;

  typedef struct packed {
    logic [ELEM_W-1:0] mul_a;
    logic [ELEM_W-1:0] mul_b;
    logic [ELEM_W-1:0] acc;
  } triple_t;

  // lanes covered by a length code, clipped to what is built
  function automatic int unsigned lane_limit(input len_e len, input int unsigned max_lanes);
    int unsigned n;
    case (len)
      LEN_128: n = 4;
      LEN_256: n = 8;
      default: n = 16;
    endcase
    return (n > max_lanes) ? max_lanes : n;
  endfunction

  // operand permutation for one lane
  function automatic triple_t route_lane(input ord_e ord, input logic [ELEM_W-1:0] d,
                                         input logic [ELEM_W-1:0] s2, input logic [ELEM_W-1:0] s3);
    triple_t t;
    case (ord)
      ORD_213: begin t.mul_a = s2; t.mul_b = d;  t.acc = s3; end
      ORD_231: begin t.mul_a = s2; t.mul_b = s3; t.acc = d;  end
      default: begin t.mul_a = d;  t.mul_b = s3; t.acc = s2; end
    endcase
    return t;
  endfunction

  function automatic logic rc_override(input len_e len, input logic mem, input logic ctl);
    return ((len == LEN_512) || (len == LEN_ALT)) && !mem && ctl;
  endfunction

  function automatic logic lane_writes(input logic mask_on, input logic mbit);
    return !mask_on || mbit;
  endfunction

  function automatic logic [ELEM_W-1:0] merge_lane(input logic active, input logic writes,
                                                   input logic zero_mode,
                                                   input logic [ELEM_W-1:0] res,
                                                   input logic [ELEM_W-1:0] old);
    if (!active)        return '0;
    else if (writes)    return res;
    else if (zero_mode) return '0;
    else                return old;
  endfunction

endpackage

// File: rtl/fmsa_router.sv
module fmsa_router
  import fmsa_pkg::*;
#(
  parameter int N_LANES = 16,
  localparam int VEC_W  = N_LANES * ELEM_W
) (
  input  logic [VEC_W-1:0]   dest,
  input  logic [VEC_W-1:0]   src2,
  input  logic [VEC_W-1:0]   src3,
  input  logic [1:0]         ord,
  input  logic [1:0]         len,
  input  logic               src3_mem,
  input  logic               ctl_bit,
  input  logic [RC_W-1:0]    rc_op,
  input  logic [RC_W-1:0]    rc_glb,
  output logic [VEC_W-1:0]   a_vec,
  output logic [VEC_W-1:0]   b_vec,
  output logic [VEC_W-1:0]   c_vec,
  output logic [N_LANES-1:0] sub_vec,
  output logic [N_LANES-1:0] act_vec,
  output logic [RC_W-1:0]    rc_sel
);

  logic              bcst_evt;
  logic              rc_ovr_evt;
  logic [ELEM_W-1:0] s3_scalar;
  int unsigned       n_act;

  assign bcst_evt   = src3_mem && ctl_bit;
  assign rc_ovr_evt = rc_override(len_e'(len), src3_mem, ctl_bit);
  assign s3_scalar  = src3[ELEM_W-1:0];
  assign n_act      = lane_limit(len_e'(len), N_LANES);
  assign rc_sel     = rc_ovr_evt ? rc_op : rc_glb;

  for (genvar j = 0; j < N_LANES; j++) begin : g_lane
    logic [ELEM_W-1:0] s3_el;
    triple_t           trip;
    assign s3_el = bcst_evt ? s3_scalar : src3[j*ELEM_W +: ELEM_W];
    assign trip  = route_lane(ord_e'(ord), dest[j*ELEM_W +: ELEM_W],
                              src2[j*ELEM_W +: ELEM_W], s3_el);
    assign a_vec[j*ELEM_W +: ELEM_W] = trip.mul_a;
    assign b_vec[j*ELEM_W +: ELEM_W] = trip.mul_b;
    assign c_vec[j*ELEM_W +: ELEM_W] = trip.acc;
    assign sub_vec[j] = (j % 2) == 1;
    assign act_vec[j] = (32'(j) < n_act);
  end

endmodule

// File: rtl/fmsa_seq.sv
module fmsa_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic op_valid,
  input  logic all_done,
  output logic op_ready,
  output logic accept,
  output logic req_valid,
  output logic take,
  output logic res_valid
);

  typedef enum logic {S_IDLE, S_WAIT} st_e;
  st_e st_q;

  assign op_ready = (st_q == S_IDLE);
  assign accept   = op_valid && op_ready;
  assign take     = (st_q == S_WAIT) && !req_valid && all_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      req_valid <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      req_valid <= accept;
      res_valid <= take;
      if (accept)    st_q <= S_WAIT;
      else if (take) st_q <= S_IDLE;
    end
  end

  p_req_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  p_req_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(op_valid && op_ready));
  p_busy_ignore_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> !req_valid);
  p_res_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

endmodule

// File: rtl/fmsa_merge.sv
module fmsa_merge
  import fmsa_pkg::*;
#(
  parameter int N_LANES = 16,
  parameter int FLAG_W  = 5,
  localparam int VEC_W  = N_LANES * ELEM_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take,
  input  logic                      out_valid,
  input  logic [VEC_W-1:0]          lane_res,
  input  logic [N_LANES*FLAG_W-1:0] lane_flags,
  input  logic [VEC_W-1:0]          old_vec,
  input  logic [N_LANES-1:0]        mask,
  input  logic                      mask_on,
  input  logic                      zero_mode,
  input  logic [1:0]                len,
  output logic [VEC_W-1:0]          res_data,
  output logic [FLAG_W-1:0]         res_flags
);

  int unsigned              n_act;
  logic [VEC_W-1:0]         merged;
  logic [N_LANES*FLAG_W-1:0] flag_gated;
  logic [FLAG_W-1:0]        flag_or;

  assign n_act = lane_limit(len_e'(len), N_LANES);

  for (genvar j = 0; j < N_LANES; j++) begin : g_lane
    logic active, writes;
    assign active = (32'(j) < n_act);
    assign writes = lane_writes(mask_on, mask[j]);
    assign merged[j*ELEM_W +: ELEM_W] = merge_lane(active, writes, zero_mode,
                                         lane_res[j*ELEM_W +: ELEM_W],
                                         old_vec[j*ELEM_W +: ELEM_W]);
    assign flag_gated[j*FLAG_W +: FLAG_W] = (active && writes) ? lane_flags[j*FLAG_W +: FLAG_W] : '0;

    p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !active) |-> (res_data[j*ELEM_W +: ELEM_W] == '0));
    p_zero_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && active && mask_on && zero_mode && !mask[j]) |-> (res_data[j*ELEM_W +: ELEM_W] == '0));
    p_merge_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && active && mask_on && !zero_mode && !mask[j])
        |-> (res_data[j*ELEM_W +: ELEM_W] == old_vec[j*ELEM_W +: ELEM_W]));
  end

  always_comb begin
    flag_or = '0;
    for (int j = 0; j < N_LANES; j++) flag_or |= flag_gated[j*FLAG_W +: FLAG_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data  <= '0;
      res_flags <= '0;
    end else if (take) begin
      res_data  <= merged;
      res_flags <= flag_or;
    end
  end

endmodule

// File: rtl/fmsa_lane_ctrl.sv
module fmsa_lane_ctrl
  import fmsa_pkg::*;
#(
  parameter int N_LANES = 16,
  parameter int FLAG_W  = 5,
  localparam int VEC_W  = N_LANES * ELEM_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  output logic                      op_ready,
  input  logic [1:0]                ord_sel,
  input  logic [1:0]                len_sel,
  input  logic                      src3_mem,
  input  logic                      ctl_bit,
  input  logic                      mask_on,
  input  logic                      zero_mode,
  input  logic [N_LANES-1:0]        mask_bits,
  input  logic [RC_W-1:0]           rc_op,
  input  logic [RC_W-1:0]           rc_glb,
  input  logic [VEC_W-1:0]          dest_in,
  input  logic [VEC_W-1:0]          src2_in,
  input  logic [VEC_W-1:0]          src3_in,
  output logic                      lane_req_valid,
  output logic [VEC_W-1:0]          lane_a,
  output logic [VEC_W-1:0]          lane_b,
  output logic [VEC_W-1:0]          lane_c,
  output logic [N_LANES-1:0]        lane_sub,
  output logic [N_LANES-1:0]        lane_act,
  output logic [RC_W-1:0]           lane_rc,
  input  logic [N_LANES-1:0]        lane_done,
  input  logic [VEC_W-1:0]          lane_res,
  input  logic [N_LANES*FLAG_W-1:0] lane_flags,
  output logic                      res_valid,
  output logic [VEC_W-1:0]          res_data,
  output logic [FLAG_W-1:0]         res_flags
);

  logic accept, take, all_done;
  logic [VEC_W-1:0]   a_nx, b_nx, c_nx;
  logic [N_LANES-1:0] sub_nx, act_nx;
  logic [RC_W-1:0]    rc_nx;

  logic [VEC_W-1:0]   dest_q;
  logic [N_LANES-1:0] mask_q;
  logic               mask_on_q, zero_q;
  logic [1:0]         len_q;

  assign all_done = &lane_done;

  fmsa_seq i_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .all_done(all_done),
    .op_ready(op_ready), .accept(accept), .req_valid(lane_req_valid),
    .take(take), .res_valid(res_valid)
  );

  fmsa_router #(.N_LANES(N_LANES)) i_router (
    .dest(dest_in), .src2(src2_in), .src3(src3_in), .ord(ord_sel), .len(len_sel),
    .src3_mem(src3_mem), .ctl_bit(ctl_bit), .rc_op(rc_op), .rc_glb(rc_glb),
    .a_vec(a_nx), .b_vec(b_nx), .c_vec(c_nx), .sub_vec(sub_nx), .act_vec(act_nx),
    .rc_sel(rc_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_a    <= '0;
      lane_b    <= '0;
      lane_c    <= '0;
      lane_sub  <= '0;
      lane_act  <= '0;
      lane_rc   <= '0;
      dest_q    <= '0;
      mask_q    <= '0;
      mask_on_q <= 1'b0;
      zero_q    <= 1'b0;
      len_q     <= '0;
    end else if (accept) begin
      lane_a    <= a_nx;
      lane_b    <= b_nx;
      lane_c    <= c_nx;
      lane_sub  <= sub_nx;
      lane_act  <= act_nx;
      lane_rc   <= rc_nx;
      dest_q    <= dest_in;
      mask_q    <= mask_bits;
      mask_on_q <= mask_on;
      zero_q    <= zero_mode;
      len_q     <= len_sel;
    end
  end

  fmsa_merge #(.N_LANES(N_LANES), .FLAG_W(FLAG_W)) i_merge (
    .clk(clk), .rst_n(rst_n), .take(take), .out_valid(res_valid),
    .lane_res(lane_res), .lane_flags(lane_flags), .old_vec(dest_q), .mask(mask_q),
    .mask_on(mask_on_q), .zero_mode(zero_q), .len(len_q),
    .res_data(res_data), .res_flags(res_flags)
  );

  p_rc_mem_glb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_req_valid && $past(src3_mem)) |-> (lane_rc == $past(rc_glb)));
  p_rc_short_glb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_req_valid && ($past(len_sel) == 2'd0)) |-> (lane_rc == $past(rc_glb)));
  p_even_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lane_req_valid |-> !lane_sub[0]);

endmodule

// File: tb/test_fmsa_lane_ctrl.sv
module test_fmsa_lane_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int EW = 32;
  localparam int FW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_ready;
  logic [1:0] ord_sel = '0, len_sel = '0;
  logic src3_mem = 1'b0, ctl_bit = 1'b0, mask_on = 1'b0, zero_mode = 1'b0;
  logic [N-1:0] mask_bits = '0;
  logic [1:0] rc_op = '0, rc_glb = '0;
  logic [N*EW-1:0] dest_in = '0, src2_in = '0, src3_in = '0;
  logic lane_req_valid;
  logic [N*EW-1:0] lane_a, lane_b, lane_c;
  logic [N-1:0] lane_sub, lane_act;
  logic [1:0] lane_rc;
  logic [N-1:0] lane_done = '0;
  logic [N*EW-1:0] lane_res = '0;
  logic [N*FW-1:0] lane_flags = '0;
  logic res_valid;
  logic [N*EW-1:0] res_data;
  logic [FW-1:0] res_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmsa_lane_ctrl i_fmsa_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .ord_sel(ord_sel), .len_sel(len_sel), .src3_mem(src3_mem), .ctl_bit(ctl_bit),
    .mask_on(mask_on), .zero_mode(zero_mode), .mask_bits(mask_bits),
    .rc_op(rc_op), .rc_glb(rc_glb), .dest_in(dest_in), .src2_in(src2_in), .src3_in(src3_in),
    .lane_req_valid(lane_req_valid), .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c),
    .lane_sub(lane_sub), .lane_act(lane_act), .lane_rc(lane_rc), .lane_done(lane_done),
    .lane_res(lane_res), .lane_flags(lane_flags), .res_valid(res_valid),
    .res_data(res_data), .res_flags(res_flags)
  );

  typedef struct {
    logic [N*EW-1:0] a, b, c;
    logic [N-1:0] sub, act;
    logic [1:0] rc;
    int dly;
    string tag;
  } req_t;
  typedef struct {
    logic [N*EW-1:0] data;
    logic [FW-1:0] flags;
    string tag;
  } res_t;

  req_t rq[$];
  res_t sq[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [N*EW-1:0] act, input logic [N*EW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // external lane unit model (stand-in arithmetic)
  function automatic logic [EW-1:0] lfn(input logic [EW-1:0] a, b, c, input logic s);
    return (a + {b[EW-2:0], 1'b0}) ^ c ^ (s ? 32'hFFFF0000 : 32'h0);
  endfunction
  function automatic logic [FW-1:0] ffn(input logic [EW-1:0] a, c);
    return (c[11:8] == 4'h0) ? FW'(5'b1 << (a[2:0] % 3'd5)) : '0;
  endfunction

  // lane model: checks requests against expectations, returns results
  req_t cur;
  initial begin
    forever begin
      @(negedge clk);
      if (lane_req_valid) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R13 unexpected request", {511'b0, lane_req_valid}, '0);
        end else begin
          logic [N*EW-1:0] am;
          cur = rq.pop_front();
          am = '0;
          for (int j = 0; j < N; j++) if (cur.act[j]) am[j*EW +: EW] = '1;
          chk(lane_act == cur.act, {cur.tag, " R1 lane_act"}, N*EW'(lane_act), N*EW'(cur.act));
          chk(lane_sub == cur.sub, {cur.tag, " R2 lane_sub"}, N*EW'(lane_sub), N*EW'(cur.sub));
          chk((lane_a & am) == (cur.a & am), {cur.tag, " lane_a"}, lane_a & am, cur.a & am);
          chk((lane_b & am) == (cur.b & am), {cur.tag, " lane_b"}, lane_b & am, cur.b & am);
          chk((lane_c & am) == (cur.c & am), {cur.tag, " lane_c"}, lane_c & am, cur.c & am);
          chk(lane_rc == cur.rc, {cur.tag, " R7 lane_rc"}, N*EW'(lane_rc), N*EW'(cur.rc));
          repeat (cur.dly) @(negedge clk);
          for (int j = 0; j < N; j++) begin
            lane_res[j*EW +: EW]   = lfn(lane_a[j*EW +: EW], lane_b[j*EW +: EW], lane_c[j*EW +: EW], lane_sub[j]);
            lane_flags[j*FW +: FW] = ffn(lane_a[j*EW +: EW], lane_c[j*EW +: EW]);
          end
          lane_done = '1;
          @(negedge clk);
          lane_done = '0;
          lane_res  = {N{32'hDEADBEEF}};
        end
      end
    end
  end

  // result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid) begin
        if (sq.size() == 0) begin
          chk(1'b0, "R13 unexpected result", {511'b0, res_valid}, '0);
        end else begin
          res_t e;
          e = sq.pop_front();
          chk(res_data == e.data, {e.tag, " res_data"}, res_data, e.data);
          chk(res_flags == e.flags, {e.tag, " R12 res_flags"}, N*EW'(res_flags), N*EW'(e.flags));
        end
        @(negedge clk);
        chk(!res_valid, "R13 res_valid one cycle", N*EW'(res_valid), '0);
      end
    end
  end

  task automatic run_op(input string tag, input logic [1:0] len, ord, input logic mem, ctl, mon, zm,
                        input logic [N-1:0] mk, input logic [1:0] rco, rcg, input int dly,
                        input bit junk, input logic [N-1:0] plant);
    logic [N*EW-1:0] d, s2, s3;
    req_t r;
    res_t e;
    int n;
    for (int j = 0; j < N; j++) begin
      d[j*EW +: EW] = $urandom; s2[j*EW +: EW] = $urandom; s3[j*EW +: EW] = $urandom;
      if (plant != '0) begin
        d[j*EW+8 +: 4] = plant[j] ? 4'h0 : 4'hF;
        s2[j*EW+8 +: 4] = plant[j] ? 4'h0 : 4'hF;
        s3[j*EW+8 +: 4] = plant[j] ? 4'h0 : 4'hF;
      end
    end
    n = (len == 2'd0) ? 4 : (len == 2'd1) ? 8 : 16;
    r.tag = tag; r.dly = dly;
    r.rc = ((len >= 2'd2) && !mem && ctl) ? rco : rcg;
    e.tag = tag; e.data = '0; e.flags = '0;
    for (int j = 0; j < N; j++) begin
      logic [EW-1:0] de, xe, ye, a, b, c;
      de = d[j*EW +: EW]; xe = s2[j*EW +: EW];
      ye = (mem && ctl) ? s3[EW-1:0] : s3[j*EW +: EW];
      if (ord == 2'd1)      begin a = xe; b = de; c = ye; end
      else if (ord == 2'd2) begin a = xe; b = ye; c = de; end
      else                  begin a = de; b = ye; c = xe; end
      r.a[j*EW +: EW] = a; r.b[j*EW +: EW] = b; r.c[j*EW +: EW] = c;
      r.sub[j] = j[0];
      r.act[j] = (j < n);
      if (j < n) begin
        if (!mon || mk[j]) begin
          e.data[j*EW +: EW] = lfn(a, b, c, j[0]);
          e.flags |= ffn(a, c);
        end else begin
          e.data[j*EW +: EW] = zm ? '0 : de;
        end
      end
    end
    do @(negedge clk); while (!op_ready);
    rq.push_back(r); sq.push_back(e);
    len_sel = len; ord_sel = ord; src3_mem = mem; ctl_bit = ctl; mask_on = mon; zero_mode = zm;
    mask_bits = mk; rc_op = rco; rc_glb = rcg; dest_in = d; src2_in = s2; src3_in = s3;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    if (junk) begin
      // R13: offer a different operation while busy; it must be ignored
      chk(!op_ready, "R13 op_ready low while busy", N*EW'(op_ready), '0);
      ord_sel = 2'd1; len_sel = 2'd0; dest_in = '1;
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(op_ready == 1'b1, "R13 reset op_ready", N*EW'(op_ready), 1);
    chk(!lane_req_valid && !res_valid, "R13 reset pulses low", N*EW'({lane_req_valid, res_valid}), 0);
    chk(res_data == '0, "R11 reset res_data", res_data, '0);

    run_op("R1 R3 R8 len512 ord132", 2'd2, 2'd0, 0, 0, 0, 0, '0, 2'd1, 2'd2, 2, 0, '0);
    run_op("R4 R11 len128 ord213",   2'd0, 2'd1, 0, 0, 0, 0, '0, 2'd1, 2'd3, 3, 0, '0);
    run_op("R5 R11 len256 ord231",   2'd1, 2'd2, 0, 0, 0, 0, '0, 2'd0, 2'd1, 1, 0, '0);
    run_op("R6 R7 bcst mem len512",  2'd2, 2'd0, 1, 1, 0, 0, '0, 2'd3, 2'd1, 2, 0, '0);
    run_op("R6 R4 bcst mem ord213",  2'd1, 2'd1, 1, 1, 0, 0, '0, 2'd3, 2'd0, 2, 0, '0);
    run_op("R7 reg override len512", 2'd2, 2'd2, 0, 1, 0, 0, '0, 2'd3, 2'd1, 2, 0, '0);
    run_op("R7 reg ctl len256",      2'd1, 2'd0, 0, 1, 0, 0, '0, 2'd3, 2'd1, 2, 0, '0);
    run_op("R7 R1 reg ctl len code3",2'd3, 2'd0, 0, 1, 0, 0, '0, 2'd2, 2'd0, 2, 0, '0);
    run_op("R9 R12 merge mask",      2'd2, 2'd0, 0, 0, 1, 0, 16'hF0F3, 2'd0, 2'd0, 2, 0, 16'h000C);
    run_op("R10 R12 zero mask",      2'd2, 2'd2, 0, 0, 1, 1, 16'h5A5B, 2'd0, 2'd0, 2, 0, 16'h0024);
    run_op("R10 R11 zero len128",    2'd0, 2'd1, 0, 0, 1, 1, 16'h0005, 2'd0, 2'd0, 2, 0, 16'h0003);
    run_op("R3 ord code3",           2'd2, 2'd3, 0, 0, 0, 0, '0, 2'd0, 2'd2, 2, 0, '0);
    run_op("R13 busy ignore",        2'd2, 2'd2, 0, 0, 0, 0, '0, 2'd0, 2'd1, 4, 1, '0);
    for (int k = 0; k < 24; k++) begin
      run_op("R8 R12 sweep", 2'(k % 4), 2'(k / 4 % 4), k[3], k[1], k[2], k[4], 16'($urandom),
             2'(k), 2'(k + 1), 1 + k % 3, 0, '0);
    end

    repeat (20) @(negedge clk);
    chk(rq.size() == 0 && sq.size() == 0, "R13 all operations completed",
        N*EW'(rq.size() + sq.size()), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R13 watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule